// File: doc/BRIEF.md
# Bus-Master DMA Bridge with Interrupt Status Ring

This block connects a LAN controller that asks for the bus with a hold/acknowledge pair to a system bus governed by a request/grant arbiter. The controller first presents a memory address with an address-latch strobe and then raises a data strobe. The bridge requests the system bus and, once granted, drives the latched address for a fixed two-clock window. It then signals ready back to the controller. On a memory write the controller's data goes out with the address. On a memory read the bus read data is passed back to the controller in the completion cycle.

A second path posts interrupt status words into a 256-entry ring in memory. When a synchronized interrupt is present and the register sequencer reports its fetch state, the bridge wins the bus. It writes the holding-register word to the address held by the ring pointer and then advances the pointer. Software loads the ring base. Only the low eight pointer bits count, so the upper bits stay fixed and the ring is reused every 256 posts.

Top module: `dma_ring_bridge`

## Requirements
- R1: `hold_ack` equals `hold_req` delayed by one clock. It falls only in a cycle after `hold_req` was low.
- R2: While `addr_stb` is high at a clock edge, the bridge captures `ctl_addr` and `ctl_rd`. Later changes on those inputs do not affect the transfer.
- R3: In idle, with `data_stb` and `hold_ack` both high and no post pending, `bus_req` rises after the next edge. It stays high, with `bus_drive` low, until `bus_gnt` is seen.
- R4: In the cycle after the grant edge, `bus_drive` is 1 and `bus_addr` is the latched address. `bus_we` is the inverse of the latched read flag (`ctl_rd`=1 means memory read), and `bus_wdata` carries `ctl_wdata`.
- R5: The drive window lasts two cycles with `bus_req` high. In the third cycle `ctl_ready` is 1, `bus_req` is 0 and `bus_drive` is 0.
- R6: During `ctl_ready` of a read transfer, `ctl_din` equals `bus_rdata`. At all other times `ctl_din` is 0.
- R7: `ctl_ready` stays high while `data_stb` stays high. It goes low one clock after `data_stb` falls, and the bridge is then idle.
- R8: In idle, with `irq_sync` and `seq_fetch` both high, `bus_req` rises after the next edge and holds until grant. The cycle after the grant edge is a single write cycle: `bus_drive`=1, `bus_we`=1, `bus_addr` is the ring pointer, and `bus_wdata` is `stat_word`.
- R9: A post then spends one release cycle with `bus_req`=0 and `bus_drive`=0. The ring pointer advances by one as the bridge returns to idle.
- R10: A cycle with `base_we` high loads the ring pointer from `base_addr`. An advance adds one to the low 8 bits modulo 256 (255 wraps to 0) and leaves the upper bits unchanged.
- R11: When a transfer and a post are requested in the same idle cycle, the post is served first. A post requested during a transfer starts only after the transfer has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_req | input | 1 | Controller bus hold request |
| hold_ack | output | 1 | Hold acknowledge to controller |
| addr_stb | input | 1 | Address latch strobe |
| ctl_addr | input | ADDR_W | Controller DMA address |
| ctl_rd | input | 1 | 1 = controller reads memory |
| data_stb | input | 1 | Controller data strobe |
| ctl_wdata | input | DATA_W | Controller write data |
| ctl_din | output | DATA_W | Read data returned to controller |
| ctl_ready | output | 1 | Transfer ready to controller |
| irq_sync | input | 1 | Synchronized controller interrupt |
| seq_fetch | input | 1 | Register sequencer is in fetch state |
| stat_word | input | DATA_W | Holding-register status word |
| base_we | input | 1 | Load ring base |
| base_addr | input | ADDR_W | Ring base address |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_drive | output | 1 | Address/data driven on system bus |
| bus_we | output | 1 | 1 = memory write |
| bus_addr | output | ADDR_W | System bus address |
| bus_wdata | output | DATA_W | System bus write data |
| bus_rdata | input | DATA_W | System bus read data |

## Verification
The assertions take certain things for granted about the controller. It raises the address strobe before the data strobe. It holds the data strobe until ready has been seen. It keeps `hold_req` high for the whole transfer. Interrupt and fetch are taken as level requests that the sequencer lowers once the bus request of the post is visible. The bench follows these rules: it changes inputs only at falling edges, pulses grant for one cycle, and drops the interrupt as soon as the post has requested the bus. No post is therefore served twice.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XWAIT = 3'd1,
    ST_XDRV  = 3'd2,
    ST_XMID  = 3'd3,
    ST_XDONE = 3'd4,
    ST_IWAIT = 3'd5,
    ST_IWR   = 3'd6,
    ST_IREL  = 3'd7
  } dmab_state_t;

  // Advance a ring pointer: low ring_w bits wrap, upper bits frozen.
  function automatic logic [63:0] ring_next(input logic [63:0] p, input int ring_w);
    logic [63:0] lo_mask;
    lo_mask = (64'd1 << ring_w) - 64'd1;
    return (p & ~lo_mask) | ((p + 64'd1) & lo_mask);
  endfunction
endpackage

// File: rtl/dmab_addr_latch.sv
module dmab_addr_latch #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rd_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else if (stb) begin
      addr_q <= addr_in;
      rd_q   <= rd_in;
    end
  end

  assert_latch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (addr_q == $past(addr_in)) && (rd_q == $past(rd_in)));
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(addr_q) && $stable(rd_q));
endmodule

// File: rtl/dmab_ring_ptr.sv
module dmab_ring_ptr #(
  parameter int ADDR_W = 24,
  parameter int RING_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);
  import dmab_pkg::*;
  localparam int HI_W = ADDR_W - RING_W;

  logic [63:0] nxt_wide;
  assign nxt_wide = ring_next(64'(ptr), RING_W);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= base;
    else if (adv)  ptr <= nxt_wide[ADDR_W-1:0];
  end

  assert_ring_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (ptr[ADDR_W-1:RING_W] == $past(ptr[ADDR_W-1:RING_W])));
  assert_ring_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (ptr[RING_W-1:0] == RING_W'($past(ptr[RING_W-1:0]) + 1'b1)));
  assert_ring_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == $past(base)));
  if (HI_W < 1) begin : g_bad
    initial $display("dmab_ring_ptr: ADDR_W must exceed RING_W");
  end
endmodule

// File: rtl/dmab_fsm.sv
module dmab_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic data_stb,
  input  logic irq_sync,
  input  logic seq_fetch,
  input  logic bus_gnt,
  output logic hold_ack,
  output logic bus_req,
  output logic drive_x,
  output logic drive_i,
  output logic done_x,
  output logic ptr_adv
);
  import dmab_pkg::*;
  dmab_state_t st, st_nx;

  // named events for checks
  logic post_start, xfer_start, waiting;
  assign post_start = (st == ST_IDLE) && irq_sync && seq_fetch;
  assign xfer_start = (st == ST_IDLE) && !post_start && data_stb && hold_ack;
  assign waiting    = (st == ST_XWAIT) || (st == ST_IWAIT);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (post_start) st_nx = ST_IWAIT;
                else if (xfer_start) st_nx = ST_XWAIT;
      ST_XWAIT: if (bus_gnt) st_nx = ST_XDRV;
      ST_XDRV:  st_nx = ST_XMID;
      ST_XMID:  st_nx = ST_XDONE;
      ST_XDONE: if (!data_stb) st_nx = ST_IDLE;
      ST_IWAIT: if (bus_gnt) st_nx = ST_IWR;
      ST_IWR:   st_nx = ST_IREL;
      ST_IREL:  st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      hold_ack <= 1'b0;
    end else begin
      st       <= st_nx;
      hold_ack <= hold_req;
    end
  end

  assign bus_req = waiting || (st == ST_XDRV) || (st == ST_XMID) || (st == ST_IWR);
  assign drive_x = (st == ST_XDRV) || (st == ST_XMID);
  assign drive_i = (st == ST_IWR);
  assign done_x  = (st == ST_XDONE);
  assign ptr_adv = (st == ST_IREL);

  assert_hack_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |-> !$past(hold_req));
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !bus_gnt) |=> bus_req && !drive_x && !drive_i);
  assert_drive_after_gnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_x || drive_i) |-> $past(bus_gnt));
  assert_ready_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_x |-> !bus_req && !drive_x);
  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_x && !data_stb) |=> !done_x && !bus_req);
  assert_post_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    post_start |=> !drive_x && bus_req);
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drive_i |=> !bus_req && ptr_adv);
  assert_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_x, drive_i, done_x, ptr_adv}));
endmodule

// File: rtl/dma_ring_bridge.sv
module dma_ring_bridge #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int RING_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_req,
  output logic              hold_ack,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic              ctl_rd,
  input  logic              data_stb,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_din,
  output logic              ctl_ready,
  input  logic              irq_sync,
  input  logic              seq_fetch,
  input  logic [DATA_W-1:0] stat_word,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_drive,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic [ADDR_W-1:0] lat_addr, ring_ptr;
  logic lat_rd, drive_x, drive_i, done_x, ptr_adv;

  dmab_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .stb(addr_stb), .addr_in(ctl_addr),
    .rd_in(ctl_rd), .addr_q(lat_addr), .rd_q(lat_rd));

  dmab_ring_ptr #(.ADDR_W(ADDR_W), .RING_W(RING_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .load(base_we), .base(base_addr),
    .adv(ptr_adv), .ptr(ring_ptr));

  dmab_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .data_stb(data_stb),
    .irq_sync(irq_sync), .seq_fetch(seq_fetch), .bus_gnt(bus_gnt),
    .hold_ack(hold_ack), .bus_req(bus_req), .drive_x(drive_x),
    .drive_i(drive_i), .done_x(done_x), .ptr_adv(ptr_adv));

  assign bus_drive = drive_x || drive_i;
  assign bus_we    = drive_i || (drive_x && !lat_rd);
  assign bus_addr  = drive_i ? ring_ptr : (drive_x ? lat_addr : '0);
  assign bus_wdata = drive_i ? stat_word : ((drive_x && !lat_rd) ? ctl_wdata : '0);
  assign ctl_ready = done_x;
  assign ctl_din   = (done_x && lat_rd) ? bus_rdata : '0;

  assert_rd_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ready |-> (ctl_din == '0));
  assert_post_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && bus_addr == ring_ptr && !drive_x) |-> bus_we);
endmodule

// File: tb/test_dma_ring_bridge.sv
`timescale 1ns/1ps
module test_dma_ring_bridge;
  localparam int AW = 24, DW = 16;
  logic clk = 0, rst_n = 0;
  logic hold_req = 0, addr_stb = 0, ctl_rd = 0, data_stb = 0;
  logic irq_sync = 0, seq_fetch = 0, base_we = 0, bus_gnt = 0;
  logic [AW-1:0] ctl_addr = '0, base_addr = '0;
  logic [DW-1:0] ctl_wdata = '0, stat_word = '0, bus_rdata = '0;
  logic hold_ack, ctl_ready, bus_req, bus_drive, bus_we;
  logic [DW-1:0] ctl_din, bus_wdata;
  logic [AW-1:0] bus_addr;
  int checks = 0, errors = 0;
  logic [AW-1:0] exp_ptr;

  always #10 clk = ~clk;

  dma_ring_bridge i_dma_ring_bridge (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
    .addr_stb(addr_stb), .ctl_addr(ctl_addr), .ctl_rd(ctl_rd),
    .data_stb(data_stb), .ctl_wdata(ctl_wdata), .ctl_din(ctl_din),
    .ctl_ready(ctl_ready), .irq_sync(irq_sync), .seq_fetch(seq_fetch),
    .stat_word(stat_word), .base_we(base_we), .base_addr(base_addr),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_drive(bus_drive),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    logic [7:0] lo;
    lo = p[7:0] + 8'd1;
    return {p[AW-1:8], lo};
  endfunction

  // one DMA transfer; 'irq_mid' raises a post request while waiting for grant
  task automatic xfer(input logic [AW-1:0] a, input logic rd, input logic [DW-1:0] wd,
                      input logic [DW-1:0] rdv, input int waits, input bit irq_mid);
    @(negedge clk);
    hold_req = 1; addr_stb = 1; ctl_addr = a; ctl_rd = rd; ctl_wdata = wd; bus_rdata = rdv;
    @(negedge clk);
    chk(hold_ack == 1, "R1 hold_ack rise", 32'(hold_ack), 1);
    addr_stb = 0; ctl_addr = ~a; ctl_rd = ~rd; data_stb = 1;
    @(negedge clk);
    chk(bus_req == 1 && bus_drive == 0, "R3 request", {bus_req, bus_drive}, 2'b10);
    if (irq_mid) begin irq_sync = 1; seq_fetch = 1; end
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk(bus_req == 1 && bus_drive == 0, "R3 wait for grant", {bus_req, bus_drive}, 2'b10);
    end
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk(bus_drive == 1 && bus_addr == a, "R4/R2 drive addr", 32'(bus_addr), 32'(a));
    chk(bus_we == !rd, "R4 direction", 32'(bus_we), 32'(!rd));
    chk(bus_wdata == (rd ? '0 : wd), "R4 write data", 32'(bus_wdata), 32'(rd ? '0 : wd));
    @(negedge clk);
    chk(bus_drive && bus_req && !ctl_ready, "R5 middle", {bus_drive, bus_req, ctl_ready}, 3'b110);
    @(negedge clk);
    chk(ctl_ready && !bus_req && !bus_drive, "R5 ready", {ctl_ready, bus_req, bus_drive}, 3'b100);
    chk(ctl_din == (rd ? rdv : '0), "R6 read data", 32'(ctl_din), 32'(rd ? rdv : '0));
    @(negedge clk);
    chk(ctl_ready == 1, "R7 ready held", 32'(ctl_ready), 1);
    data_stb = 0;
    @(negedge clk);
    chk(!ctl_ready && !bus_req && ctl_din == '0, "R7 idle", {ctl_ready, bus_req}, 0);
    hold_req = 0;
    @(negedge clk);
    chk(hold_ack == 0, "R1 hold_ack fall", 32'(hold_ack), 0);
  endtask

  // one status post; 'started' means the request is already visible
  task automatic post(input logic [DW-1:0] sw, input bit started);
    stat_word = sw;
    if (!started) begin
      @(negedge clk);
      irq_sync = 1; seq_fetch = 1;
      @(negedge clk);
    end
    chk(bus_req == 1 && bus_drive == 0, "R8 post request", {bus_req, bus_drive}, 2'b10);
    irq_sync = 0; seq_fetch = 0;
    @(negedge clk);
    chk(bus_req == 1 && bus_drive == 0, "R8 post wait", {bus_req, bus_drive}, 2'b10);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk(bus_drive && bus_we && bus_addr == exp_ptr, "R8 ring addr", 32'(bus_addr), 32'(exp_ptr));
    chk(bus_wdata == sw, "R8 status data", 32'(bus_wdata), 32'(sw));
    @(negedge clk);
    chk(!bus_req && !bus_drive, "R9 release", {bus_req, bus_drive}, 0);
    exp_ptr = bump(exp_ptr);
    @(negedge clk);
    chk(!bus_req, "R9 back to idle", 32'(bus_req), 0);
  endtask

  // address, rd, wdata, rdata, grant-wait cycles
  localparam logic [63:0] VEC [0:3] = '{
    {24'h00_1000, 1'b0, 16'hBEEF, 16'h0000, 7'd0},
    {24'h3F_FFFE, 1'b1, 16'h1111, 16'hA5C3, 7'd2},
    {24'h80_0002, 1'b0, 16'h0F0F, 16'h9999, 7'd3},
    {24'h12_3456, 1'b1, 16'h0000, 16'hFFFF, 7'd1}
  };

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!hold_ack && !bus_req && !ctl_ready && !bus_drive, "reset state R1 R5",
        {hold_ack, bus_req, ctl_ready, bus_drive}, 0);
    rst_n = 1;
    base_we = 1; base_addr = 24'h12_34FE;
    @(negedge clk);
    base_we = 0; base_addr = '0; exp_ptr = 24'h12_34FE;

    foreach (VEC[i])
      xfer(VEC[i][63:40], VEC[i][39], VEC[i][38:23], VEC[i][22:7], int'(VEC[i][6:0]), 0);

    // R10: wrap of low 8 bits, upper bits frozen
    post(16'h0001, 0);
    post(16'h0002, 0);
    chk(exp_ptr == 24'h12_3400, "R10 bench wrap model", 32'(exp_ptr), 32'h12_3400);
    post(16'h0003, 0);

    // R11: post arriving during transfer waits for idle
    xfer(24'h00_0ABC, 1'b0, 16'h5555, 16'h0, 1, 1);
    post(16'h0004, 1);

    // R11: simultaneous requests -> post first
    @(negedge clk);
    hold_req = 1; addr_stb = 1; ctl_addr = 24'h44_0010; ctl_rd = 0; ctl_wdata = 16'h7777;
    @(negedge clk);
    addr_stb = 0; data_stb = 1; irq_sync = 1; seq_fetch = 1; stat_word = 16'h00AA;
    @(negedge clk);
    irq_sync = 0; seq_fetch = 0; bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk(bus_drive && bus_addr == exp_ptr, "R11 post served first", 32'(bus_addr), 32'(exp_ptr));
    exp_ptr = bump(exp_ptr);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(bus_req && !bus_drive, "R11 transfer follows", {bus_req, bus_drive}, 2'b10);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk(bus_drive && bus_addr == 24'h44_0010, "R11 transfer addr", 32'(bus_addr), 32'h44_0010);
    @(negedge clk);
    @(negedge clk);
    chk(ctl_ready == 1, "R5 ready after priority", 32'(ctl_ready), 1);
    data_stb = 0; hold_req = 0;
    @(negedge clk);
    post(16'h0005, 0);

    // R10: reload base, pointer follows new base
    @(negedge clk);
    base_we = 1; base_addr = 24'h7F_00FF;
    @(negedge clk);
    base_we = 0; exp_ptr = 24'h7F_00FF;
    post(16'h0006, 0);
    post(16'h0007, 0);
    chk(exp_ptr[23:8] == 16'h7F00, "R10 upper frozen", 32'(exp_ptr[23:8]), 32'h7F00);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule